// File: doc/BRIEF.md
# Indexed Colour Lookup Table with Auto-Incrementing Write Port

This block holds a 256-entry colour table, each entry an 8-bit red, green and blue triple. A host programs it over a small 32-bit register window of four words. A write to the first word selects the entry to program. Successive writes to the second word then fill that entry's red, green and blue values, one per write. After the blue write the block moves on to the next entry by itself, so a whole table can be streamed in after a single index write.

Every component value comes from the most significant byte of the written word. Each write changes the table at once, without waiting for the other two components of the entry. A separate lookup port serves a pixel pipeline. It takes an 8-bit pixel code and returns the 24-bit colour one clock later from an output register.

Top module: `pal_clut`

## Requirements
- R1: A write with `bus_woff` = 0 loads the entry pointer from `bus_wdata[31:24]` and returns the component sequencer to red, even if it was partway through a triple.
- R2: A write with `bus_woff` = 1 (byte offset 4) stores `bus_wdata[31:24]` into the entry the pointer selects. The first such write goes to red, the second to green and the third to blue.
- R3: After a blue write the pointer advances by one modulo 256 (255 wraps to 0) and the sequencer returns to red.
- R4: Each component write is visible to the lookup port on the next clock edge, even when the rest of the triple has not been written yet.
- R5: A lookup code presented at a rising edge appears on `pix_rgb` after that edge. The colour is packed as red in [23:16], green in [15:8] and blue in [7:0].
- R6: When a component write and a lookup of the same entry share a clock edge, the lookup returns the value the entry held before the write.
- R7: `bus_rdata` reads as zero at all times.
- R8: Writes with `bus_woff` = 2 or 3 are ignored, and cycles with `bus_we` low change nothing, whatever the offset and data.
- R9: After reset, entries 0 to 254 are black (0,0,0) and entry 255 is white (255,255,255). The pointer is 0, the sequencer is at red, and `pix_rgb` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Register write strobe, one 32-bit word per cycle |
| bus_woff | input | 2 | Word offset inside the 16-byte register window |
| bus_wdata | input | 32 | Write data; only bits 31:24 are used |
| bus_rdata | output | 32 | Read data, always zero |
| pix_idx | input | 8 | Pixel code to look up |
| pix_rgb | output | 24 | Registered colour of the code sampled at the last edge |

## Verification
The pointer and the sequencer cannot be observed directly, so a fault in either one shows up as a colour landing in the wrong entry or the wrong component. Such a fault becomes visible on `pix_rgb` one edge after that entry is looked up. The bench therefore looks up the affected entries right after each write pattern: a mid-triple pointer reload, the 255-to-0 wrap, writes to the ignored offsets, and a write and a lookup of the same entry on one edge. A reset fault shows on the very first lookups of entries 0, 254 and 255.

// File: rtl/pal_clut.sv
module pal_clut #(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8,
  parameter int BUS_W  = 32,
  parameter int OFF_W  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_we,
  input  logic [OFF_W-1:0]      bus_woff,
  input  logic [BUS_W-1:0]      bus_wdata,
  output logic [BUS_W-1:0]      bus_rdata,
  input  logic [IDX_W-1:0]      pix_idx,
  output logic [3*COMP_W-1:0]   pix_rgb
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [OFF_W-1:0] OFF_PTR = OFF_W'(0);
  localparam logic [OFF_W-1:0] OFF_DAT = OFF_W'(1);
  localparam logic [1:0] PH_R = 2'd0;
  localparam logic [1:0] PH_G = 2'd1;
  localparam logic [1:0] PH_B = 2'd2;

  logic [IDX_W-1:0]  idx_q;
  logic [1:0]        phase_q;
  logic              sel_ptr, sel_dat;
  logic [COMP_W-1:0] comp;

  assign sel_ptr   = bus_we && (bus_woff == OFF_PTR);
  assign sel_dat   = bus_we && (bus_woff == OFF_DAT);
  assign comp      = bus_wdata[BUS_W-1 -: COMP_W];
  assign bus_rdata = '0;

  logic unused_low;
  assign unused_low = &{1'b0, bus_wdata[BUS_W-COMP_W-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      phase_q <= PH_R;
    end else if (sel_ptr) begin
      idx_q   <= bus_wdata[BUS_W-1 -: IDX_W];
      phase_q <= PH_R;
    end else if (sel_dat) begin
      if (phase_q == PH_B) begin
        idx_q   <= idx_q + 1'b1;
        phase_q <= PH_R;
      end else begin
        phase_q <= phase_q + 2'd1;
      end
    end
  end

  for (genvar p = 0; p < 3; p++) begin : g_plane
    logic [COMP_W-1:0] mem [DEPTH];
    logic [COMP_W-1:0] rd_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++)
          mem[i] <= (i == DEPTH-1) ? {COMP_W{1'b1}} : '0;
        rd_q <= '0;
      end else begin
        if (sel_dat && phase_q == 2'(p))
          mem[idx_q] <= comp;
        rd_q <= mem[pix_idx];
      end
    end

    assign pix_rgb[(2-p)*COMP_W +: COMP_W] = rd_q;
  end
endmodule

// File: rtl/pal_clut_chk.sv
module pal_clut_chk #(
  parameter int IDX_W = 8,
  parameter int OFF_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_we,
  input logic [OFF_W-1:0] bus_woff,
  input logic [IDX_W-1:0] top_byte,
  input logic [IDX_W-1:0] wr_idx,
  input logic [1:0]       wr_phase
);
  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_woff == OFF_W'(0)) |=> (wr_idx == $past(top_byte) && wr_phase == 2'd0)); // R1

  AST_RED_TO_GREEN: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_woff == OFF_W'(1) && wr_phase == 2'd0) |=> (wr_phase == 2'd1 && $stable(wr_idx))); // R2

  AST_GREEN_TO_BLUE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_woff == OFF_W'(1) && wr_phase == 2'd1) |=> (wr_phase == 2'd2 && $stable(wr_idx))); // R2

  AST_BLUE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_woff == OFF_W'(1) && wr_phase == 2'd2) |=> (wr_phase == 2'd0 && wr_idx == IDX_W'($past(wr_idx) + 1'b1))); // R3

  AST_IGNORED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we || bus_woff > OFF_W'(1)) |=> ($stable(wr_idx) && $stable(wr_phase))); // R8

  AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_phase != 2'd3); // R2
endmodule

bind pal_clut pal_clut_chk #(.IDX_W(IDX_W), .OFF_W(OFF_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_we   (bus_we),
  .bus_woff (bus_woff),
  .top_byte (bus_wdata[BUS_W-1 -: IDX_W]),
  .wr_idx   (idx_q),
  .wr_phase (phase_q)
);

// File: tb/pal_clut_tb_top.sv
`timescale 1ns/1ps
module pal_clut_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_woff = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  pix_idx = '0;
  logic [23:0] pix_rgb;

  always #2 clk = ~clk;

  pal_clut dut_i (.*);

  int total = 0;
  int bad = 0;

  logic [7:0] m_r [256];
  logic [7:0] m_g [256];
  logic [7:0] m_b [256];
  logic [7:0] m_idx;
  int         m_ph;

  logic [23:0] exp_q [$];
  string       tag_q [$];

  function automatic logic [23:0] model_rgb(logic [7:0] i);
    return {m_r[i], m_g[i], m_b[i]};
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 256; i++) begin
      m_r[i] = (i == 255) ? 8'hff : 8'h00;
      m_g[i] = (i == 255) ? 8'hff : 8'h00;
      m_b[i] = (i == 255) ? 8'hff : 8'h00;
    end
    m_idx = '0;
    m_ph  = 0;
  endtask

  task automatic model_write(logic [1:0] off, logic [7:0] v);
    if (off == 2'd0) begin
      m_idx = v;
      m_ph  = 0;
    end else if (off == 2'd1) begin
      case (m_ph)
        0: m_r[m_idx] = v;
        1: m_g[m_idx] = v;
        default: m_b[m_idx] = v;
      endcase
      if (m_ph == 2) begin
        m_idx = m_idx + 8'd1;
        m_ph  = 0;
      end else begin
        m_ph = m_ph + 1;
      end
    end
  endtask

  // One cycle: optional write, optional lookup, both at the same edge.
  task automatic step(input logic we, input logic [1:0] off, input logic [7:0] v,
                      input logic look, input logic [7:0] li, input string tag);
    @(negedge clk);
    bus_we    = we;
    bus_woff  = off;
    bus_wdata = {v, 24'h5a_c3_96};
    pix_idx   = li;
    if (look) begin
      exp_q.push_back(model_rgb(li));
      tag_q.push_back(tag);
    end
    if (we) model_write(off, v);
  endtask

  task automatic wr(input logic [1:0] off, input logic [7:0] v);
    step(1'b1, off, v, 1'b0, 8'd0, "");
  endtask

  task automatic look(input logic [7:0] li, input string tag);
    step(1'b0, 2'd0, 8'd0, 1'b1, li, tag);
  endtask

  task automatic idle();
    step(1'b0, 2'd0, 8'd0, 1'b0, 8'd0, "");
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_q.size() != 0) begin
      logic [23:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (pix_rgb !== e) begin
        bad++;
        $display("FAIL %s: pix_rgb=%06h expected=%06h", t, pix_rgb, e);
      end
    end
  end

  task automatic check_rdata(string t);
    total++;
    if (bus_rdata !== 32'h0) begin
      bad++;
      $display("FAIL %s: bus_rdata=%08h expected=00000000", t, bus_rdata);
    end
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    model_reset();
    #1;
    total++;
    if (pix_rgb !== 24'h0) begin
      bad++;
      $display("FAIL R9: pix_rgb in reset=%06h expected=000000", pix_rgb);
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check_rdata("R7 after reset");

    // R9 reset contents
    look(8'd0,   "R9 entry 0 black");
    look(8'd254, "R9 entry 254 black");
    look(8'd255, "R9 entry 255 white");
    look(8'd77,  "R9 entry 77 black");

    // R9 pointer 0 / red after reset; R2 order; R5 packing
    wr(2'd1, 8'h11);
    look(8'd0, "R4 red only visible");
    wr(2'd1, 8'h22);
    wr(2'd1, 8'h33);
    look(8'd0, "R2 R5 R9 entry 0 full triple");
    // R3 pointer moved to 1
    wr(2'd1, 8'h44);
    look(8'd1, "R3 next entry red");

    // R1 reload mid-triple resets to red
    wr(2'd0, 8'd20);
    wr(2'd1, 8'ha1);
    wr(2'd1, 8'ha2);
    wr(2'd0, 8'd30);
    wr(2'd1, 8'hb1);
    look(8'd20, "R1 entry 20 partial");
    look(8'd30, "R1 entry 30 red after reload");

    // R8 ignored offsets and no-strobe cycles
    wr(2'd2, 8'hee);
    wr(2'd3, 8'hdd);
    step(1'b0, 2'd1, 8'hcc, 1'b0, 8'd0, "");
    step(1'b0, 2'd0, 8'h99, 1'b0, 8'd0, "");
    wr(2'd1, 8'hb2);
    look(8'd30, "R8 green lands after ignored writes");
    look(8'd153, "R8 no strobe left entry 153 untouched");
    check_rdata("R7 after writes");

    // R3 wrap 255 -> 0
    wr(2'd0, 8'd255);
    wr(2'd1, 8'h01);
    wr(2'd1, 8'h02);
    wr(2'd1, 8'h03);
    wr(2'd1, 8'h0a);
    look(8'd255, "R3 entry 255 rewritten");
    look(8'd0,   "R3 wrap to entry 0");

    // R6 collision then R4 next edge
    wr(2'd0, 8'd10);
    step(1'b1, 2'd1, 8'h7e, 1'b1, 8'd10, "R6 same-edge read old red");
    look(8'd10, "R4 red seen next edge");
    step(1'b1, 2'd1, 8'h6d, 1'b1, 8'd10, "R6 same-edge read old green");
    step(1'b1, 2'd1, 8'h5c, 1'b1, 8'd10, "R4 R6 green new blue old");
    look(8'd10, "R2 entry 10 complete");

    // Stream a run of entries, back-to-back lookups
    wr(2'd0, 8'd100);
    for (int k = 0; k < 24; k++) wr(2'd1, 8'(k * 7 + 3));
    for (int k = 96; k < 112; k++) look(8'(k), "R3 R5 streamed entries");
    check_rdata("R7 end");

    idle();
    idle();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule